// File: doc/BRIEF.md
# I2C command frame decoder

This block sits behind a byte-level I2C target front end. The front end reports start conditions (a repeated start counts as a start), stop conditions and received bytes. The decoder treats the first byte after a start as the address byte. A write-direction frame then carries a three-byte command word, an optional payload and an optional CRC-8 byte. The command word selects the direction, CRC checking, a payload length of 16, 32 or 64 bits, and a location given as section, page and 12-bit offset.

A write frame is held until its stop condition. The block commits it as a single memory write request only when three checks pass: the byte count matches the length code, the location is not reserved, and the CRC is correct. A read frame carries only its command word. It arms a read, and a later read-direction address byte consumes that read, whether it comes after a repeated start or after a stop and a fresh start. The memory word that comes back is loaded into a shift register. The front end takes bytes from that register, least significant first.

Top module: `i2c_cmd_frame_dec`

## Requirements
- R1: The address byte (bits 7:1 target address, bit 0 direction, 1 = read) is acknowledged only when the address equals parameter TGT_ADDR (default 0x2A) and either the direction is write, or it is read while a read is armed. An unacknowledged address byte, and every later byte up to the next start, gets no `ack` pulse. Any byte that is acknowledged gives a one-cycle `ack` pulse in the cycle after `byte_vld`.
- R2: The command word arrives most significant byte first. Its fields are: bit 23 operation (1 read, 0 write), bit 22 CRC enable, bits 21:20 length code, bits 19:16 section, bits 15:12 page, bits 11:0 offset. `mem_addr` shows the offset and `acc_len` shows the length code.
- R3: `wr_req` pulses for exactly one cycle, in the cycle after `ev_stop`. It pulses only for a write frame whose count of post-command bytes equals 2, 4 or 8 (for length codes 00, 01 and 10), plus 1 when CRC is enabled.
- R4: Payload bytes fill `wr_data` least significant byte first. Bytes above the payload length read zero, and the CRC byte is never stored.
- R5: With CRC enabled, the last byte must equal the CRC-8 (polynomial 0x07, initial value 0xFF, MSB first, no final XOR) of the address byte, the command bytes and the payload. On a mismatch the write is discarded.
- R6: A command whose section or page is non-zero produces neither `wr_req` nor an armed read. A read-direction address byte that follows such a read command is not acknowledged.
- R7: Length code 11 sets `err_len` in the cycle after the third command byte. The frame is discarded, and `err_len` stays set until reset.
- R8: A write frame cut off by a start before its stop never raises `wr_req`.
- R9: A read command followed by zero payload bytes arms a read at the next start or stop. The matching read-direction address byte then raises `rd_req` for one cycle, in the cycle after that byte, with `mem_addr` holding the offset. A read command followed by any payload byte is not armed.
- R10: The shift register loads `rd_data` at the second clock edge after `rd_req` rises (memory has one cycle of latency). `tx_byte` shows bits 7:0 of the register. Each cycle with `tx_next` high shifts it down by one byte, and zeros fill in from the top.
- R11: An armed read is consumed by one read-direction address byte. A later read address, or a read address that follows an intervening write-direction frame, is not acknowledged.
- R12: During and after reset, `ack`, `wr_req`, `rd_req`, `err_len` and `tx_byte` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | Start or repeated start seen |
| ev_stop | input | 1 | Stop seen |
| byte_vld | input | 1 | A received byte is on `byte_data` |
| byte_data | input | 8 | Received byte |
| ack | output | 1 | Pulse: last byte acknowledged |
| wr_req | output | 1 | Memory write request pulse |
| rd_req | output | 1 | Memory read request pulse |
| mem_addr | output | 12 | Offset from the command word |
| acc_len | output | 2 | Length code from the command word |
| wr_data | output | 64 | Assembled write payload |
| rd_data | input | 64 | Memory read word, valid one cycle after `rd_req` |
| tx_next | input | 1 | Advance the read shift register by one byte |
| tx_byte | output | 8 | Current read byte |
| err_len | output | 1 | Sticky reserved-length flag |

## Verification
The hardest states to reach from the ports are those that depend on how a frame ends. A write must survive a correct-count, correct-CRC payload and still be dropped because a repeated start arrived before the stop. A read must stay armed across either a repeated start or a full stop and new start, and then be disarmed by one consumption or by an intervening write. The vector table varies how each frame ends, the payload count and the CRC byte (correct, corrupted or missing). Directed sequences then chain read commands, read addresses and writes so that arming, consumption and cancellation each occur.

// File: rtl/i2c_cmd_frame_dec.sv
module i2c_cmd_frame_dec #(
  parameter logic [6:0] TGT_ADDR = 7'h2A,
  parameter logic [7:0] CRC_POLY = 8'h07,
  parameter logic [7:0] CRC_INIT = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_start,
  input  logic        ev_stop,
  input  logic        byte_vld,
  input  logic [7:0]  byte_data,
  output logic        ack,
  output logic        wr_req,
  output logic        rd_req,
  output logic [11:0] mem_addr,
  output logic [1:0]  acc_len,
  output logic [63:0] wr_data,
  input  logic [63:0] rd_data,
  input  logic        tx_next,
  output logic [7:0]  tx_byte,
  output logic        err_len
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_DATA, S_TX, S_SKIP} st_t;

  st_t         st;
  logic [23:0] cmd;
  logic [1:0]  ccnt;
  logic [3:0]  dcnt;
  logic [7:0]  crc;
  logic [63:0] dat, sh;
  logic        armed, ld_q;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int i = 0; i < 8; i++)
      r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction

  wire [3:0] nbytes  = 4'd2 << cmd[21:20];
  wire [3:0] expect_n = nbytes + {3'b000, cmd[22]};
  wire       len_ok  = cmd[21:20] != 2'b11;
  wire       loc_ok  = cmd[19:12] == 8'h00;
  wire       crc_ok  = !cmd[22] || crc == 8'h00;
  wire       wr_ok   = !cmd[23] && len_ok && loc_ok && dcnt == expect_n && crc_ok;
  wire       rd_ok   = cmd[23] && len_ok && loc_ok && dcnt == 4'd0;
  wire       adr_hit = byte_data[7:1] == TGT_ADDR;

  assign mem_addr = cmd[11:0];
  assign acc_len  = cmd[21:20];
  assign wr_data  = dat;
  assign tx_byte  = sh[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cmd     <= '0;
      ccnt    <= '0;
      dcnt    <= '0;
      crc     <= '0;
      dat     <= '0;
      sh      <= '0;
      armed   <= 1'b0;
      ld_q    <= 1'b0;
      ack     <= 1'b0;
      wr_req  <= 1'b0;
      rd_req  <= 1'b0;
      err_len <= 1'b0;
    end else begin
      ack    <= 1'b0;
      wr_req <= 1'b0;
      rd_req <= 1'b0;
      ld_q   <= rd_req;
      if (ld_q)         sh <= rd_data;
      else if (tx_next) sh <= {8'h00, sh[63:8]};

      if (ev_stop) begin
        if (st == S_DATA) begin
          wr_req <= wr_ok;
          armed  <= rd_ok;
        end
        st <= S_IDLE;
      end else if (ev_start) begin
        if (st == S_DATA) armed <= rd_ok;
        st <= S_ADDR;
      end else if (byte_vld) begin
        case (st)
          S_ADDR: begin
            if (!adr_hit) begin
              st <= S_SKIP;
            end else if (!byte_data[0]) begin
              st    <= S_CMD;
              ack   <= 1'b1;
              armed <= 1'b0;
              ccnt  <= '0;
              dcnt  <= '0;
              dat   <= '0;
              crc   <= crc_step(CRC_INIT, byte_data);
            end else if (armed) begin
              st     <= S_TX;
              ack    <= 1'b1;
              rd_req <= 1'b1;
              armed  <= 1'b0;
            end else begin
              st <= S_SKIP;
            end
          end
          S_CMD: begin
            ack  <= 1'b1;
            cmd  <= {cmd[15:0], byte_data};
            crc  <= crc_step(crc, byte_data);
            ccnt <= ccnt + 2'd1;
            if (ccnt == 2'd2) begin
              st <= S_DATA;
              if (cmd[13:12] == 2'b11) err_len <= 1'b1;
            end
          end
          S_DATA: begin
            ack <= 1'b1;
            crc <= crc_step(crc, byte_data);
            if (dcnt != 4'hF) dcnt <= dcnt + 4'd1;
            if (!dcnt[3] && dcnt < nbytes)
              dat[{dcnt[2:0], 3'b000} +: 8] <= byte_data;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_cmd_frame_dec_chk.sv
module i2c_cmd_frame_dec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_stop,
  input logic       byte_vld,
  input logic       ack,
  input logic       wr_req,
  input logic       rd_req,
  input logic       err_len,
  input logic [7:0] sel
);

  // R1
  ack_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(byte_vld));

  // R3
  wr_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> $past(ev_stop));

  // R3
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);

  // R6
  no_reserved_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req || rd_req) |-> sel == 8'h00);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_len |=> err_len);

  // R9
  rd_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> $past(byte_vld));

  // R11
  rd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

endmodule

bind i2c_cmd_frame_dec i2c_cmd_frame_dec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_stop(ev_stop), .byte_vld(byte_vld),
  .ack(ack), .wr_req(wr_req), .rd_req(rd_req), .err_len(err_len),
  .sel(cmd[19:12])
);

// File: tb/sim_i2c_cmd_frame_dec.sv
module sim_i2c_cmd_frame_dec;
  localparam logic [7:0] ADW = 8'h54;
  localparam logic [7:0] ADR = 8'h55;

  // {cmd[23:0], nbytes[3:0], crcsel[1:0] (0 none,1 good,2 bad), rstart, expect_commit}
  localparam logic [31:0] VEC [12] = '{
    32'h00010021, 32'h10023441, 32'h20080081, 32'h40001025,
    32'h6007FF85, 32'h50002048, 32'h00010030, 32'h10010030,
    32'h01010020, 32'h00110020, 32'h00010022, 32'h40001020
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_start = 0, ev_stop = 0, byte_vld = 0, tx_next = 0;
  logic [7:0] byte_data = 0;
  logic ack, wr_req, rd_req, err_len;
  logic [11:0] mem_addr;
  logic [1:0] acc_len;
  logic [63:0] wr_data, mem_q;
  logic [7:0] tx_byte;
  int checks = 0, errs = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) mem_q <= '0;
    else if (rd_req) mem_q <= {52'h0F1E2D3C4B5A6, mem_addr};

  i2c_cmd_frame_dec u0 (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .byte_vld(byte_vld), .byte_data(byte_data), .ack(ack), .wr_req(wr_req),
    .rd_req(rd_req), .mem_addr(mem_addr), .acc_len(acc_len), .wr_data(wr_data),
    .rd_data(mem_q), .tx_next(tx_next), .tx_byte(tx_byte), .err_len(err_len)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] crcb(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[7] ^ b[i];
      r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return r;
  endfunction

  task automatic do_start();
    @(negedge clk) ev_start = 1;
    @(negedge clk) ev_start = 0;
  endtask

  task automatic do_stop();
    @(negedge clk) ev_stop = 1;
    @(negedge clk) ev_stop = 0;
  endtask

  task automatic send(input logic [7:0] b, output logic a);
    @(negedge clk) begin byte_vld = 1; byte_data = b; end
    @(negedge clk) byte_vld = 0;
    a = ack;
  endtask

  task automatic send_cmd(input logic [23:0] c);
    logic a;
    do_start();
    send(ADW, a);
    send(c[23:16], a);
    send(c[15:8], a);
    send(c[7:0], a);
  endtask

  task automatic run_vec(input int k);
    logic [31:0] v = VEC[k];
    logic [23:0] c = v[31:8];
    logic [3:0] n = v[7:4];
    logic [7:0] cr = 8'hFF;
    logic [63:0] ed = '0;
    int nb = 2 << c[21:20];
    logic a;
    do_start();
    send(ADW, a);
    chk(a == 1, $sformatf("R1 vec%0d address ack", k), a, 1);
    cr = crcb(cr, ADW);
    for (int i = 2; i >= 0; i--) begin
      send(c[8*i +: 8], a);
      cr = crcb(cr, c[8*i +: 8]);
    end
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = (8'h11 * (i + 1)) ^ 8'(k);
      send(b, a);
      cr = crcb(cr, b);
      if (i < nb) ed[8*i +: 8] = b;
    end
    if (v[3:2] == 2'd1) send(cr, a);
    if (v[3:2] == 2'd2) send(cr ^ 8'h5A, a);
    if (v[1]) begin
      do_start();
      do_stop();
      chk(wr_req == 0, $sformatf("R8 vec%0d aborted write", k), wr_req, 0);
    end else begin
      do_stop();
      chk(wr_req == v[0], $sformatf("R3 R5 R6 vec%0d commit", k), wr_req, v[0]);
      if (v[0]) begin
        chk(wr_data == ed, $sformatf("R4 vec%0d data", k), wr_data, ed);
        chk(mem_addr == c[11:0] && acc_len == c[21:20], $sformatf("R2 vec%0d fields", k),
            {mem_addr, acc_len}, {c[11:0], c[21:20]});
      end
    end
    @(negedge clk);
    chk(wr_req == 0, $sformatf("R3 vec%0d single pulse", k), wr_req, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [63:0] ex;
    repeat (3) @(negedge clk);
    chk({ack, wr_req, rd_req, err_len, tx_byte} == 0, "R12 reset outputs",
        {ack, wr_req, rd_req, err_len, tx_byte}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < 12; k++) run_vec(k);

    // R1: foreign address, all bytes ignored
    do_start();
    send(8'h56, a);
    chk(a == 0, "R1 foreign address nack", a, 0);
    send(8'h00, a);
    chk(a == 0, "R1 bytes after nack", a, 0);
    do_stop();
    chk(wr_req == 0, "R1 no commit after nack", wr_req, 0);

    // R7: reserved length
    send_cmd(24'h300100);
    chk(err_len == 1, "R7 err after third command byte", err_len, 1);
    for (int i = 0; i < 8; i++) send(8'hA0, a);
    do_stop();
    chk(wr_req == 0, "R7 reserved length discarded", wr_req, 0);

    // R9 R10: read via repeated start
    send_cmd(24'h800123);
    do_start();
    send(ADR, a);
    chk(a == 1 && rd_req == 1, "R9 read after repeated start", {a, rd_req}, 2'b11);
    chk(mem_addr == 12'h123, "R9 read offset", mem_addr, 12'h123);
    ex = {52'h0F1E2D3C4B5A6, 12'h123};
    @(negedge clk);
    chk(rd_req == 0, "R9 rd_req single pulse", rd_req, 0);
    @(negedge clk);
    chk(tx_byte == ex[7:0], "R10 first read byte", tx_byte, ex[7:0]);
    for (int j = 1; j < 4; j++) begin
      @(negedge clk) tx_next = 1;
      @(negedge clk) tx_next = 0;
      chk(tx_byte == ex[8*j +: 8], $sformatf("R10 read byte %0d", j), tx_byte, ex[8*j +: 8]);
    end
    do_stop();

    // R9 R11: read via stop then start, then consumed
    send_cmd(24'h900456);
    do_stop();
    do_start();
    send(ADR, a);
    chk(a == 1 && rd_req == 1, "R9 read after stop and start", {a, rd_req}, 2'b11);
    do_stop();
    do_start();
    send(ADR, a);
    chk(a == 0 && rd_req == 0, "R11 second read nack", {a, rd_req}, 0);
    do_stop();

    // R6: reserved page read
    send_cmd(24'h801123);
    do_start();
    send(ADR, a);
    chk(a == 0 && rd_req == 0, "R6 reserved read not armed", {a, rd_req}, 0);
    do_stop();

    // R11: write frame cancels armed read
    send_cmd(24'h800200);
    do_stop();
    send_cmd(24'h000300);
    send(8'h12, a);
    send(8'h34, a);
    do_stop();
    chk(wr_req == 1 && wr_data == 64'h3412, "R4 write between reads",
        {wr_req, wr_data}, {1'b1, 64'h3412});
    do_start();
    send(ADR, a);
    chk(a == 0, "R11 write cancels armed read", a, 0);
    do_stop();

    // R9: read command with a payload byte is not armed
    send_cmd(24'h800100);
    send(8'h77, a);
    do_start();
    send(ADR, a);
    chk(a == 0 && rd_req == 0, "R9 read with payload not armed", {a, rd_req}, 0);
    do_stop();

    chk(err_len == 1, "R7 err flag sticky", err_len, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule